// File: doc/BRIEF.md
# I2C Slave Address and Reserved-Code Decoder

This block watches a synchronised two-wire bus (clock and data, already brought into the system clock domain) and decides, for every byte that opens a transfer, whether the device answers. Each start or repeated start begins an address phase. Eight data bits are shifted in on the rising clock edges, MSB first. The block then compares the upper seven bits with the device's own address. That address is a parameter-fixed upper field joined to a programmable lower field. The block also sorts the byte into one of the reserved classes, drives the acknowledge on the ninth clock and latches the transfer direction.

A general call that the host has enabled is acknowledged, and the block then reads one more byte. An even second byte is a command: 0x06 resets and reloads the programmable field from its pins, and 0x04 only reloads it. An odd second byte carries the seven-bit address of the calling master, which is passed on to the host. Payload bytes, clock stretching and the second byte of a ten-bit address are left to other logic.

The controller has six states:
- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting the first byte.
- `ST_GCALL`: shifting the byte that follows an accepted general call.
- `ST_ACK`: the ninth clock slot.
- `ST_SEL`: addressed; the payload is handled elsewhere.
- `ST_SKIP`: not concerned until the next start or stop.

Its transitions are:
- Any state goes to `ST_ADDR` on a start or repeated start.
- Any state goes to `ST_IDLE` on a stop.
- `ST_ADDR` and `ST_GCALL` go to `ST_ACK` at the falling clock edge that ends the eighth bit.
- `ST_ACK` goes, at the falling edge that ends the ninth clock, to the state chosen when the byte was decided:
  - from the address byte: `ST_SEL` on an own-address match, `ST_GCALL` on an accepted general call, `ST_SKIP` otherwise;
  - from the general-call byte: always `ST_SKIP`.

Top module: `i2c_adec`

## Requirements
- R1: After a start, the 8 bits sampled on SCL rising edges form the address byte, first bit in the MSB. At the falling edge after the eighth bit, `cls_stb_o` pulses once and `cls_o` gives the class of the byte. The classes are: 0 other, 1 own, 2 general call, 3 start byte, 4 bus-compatibility code, 5 high-speed master code, 6 ten-bit prefix, 7 other reserved.
- R2: The own address is `{FIX_ADDR, prog}`, and `own_addr_o` shows it. `prog` resets to `PROG_INIT` and changes only on a general-call reload command.
- R3: An address byte whose upper seven bits equal the own address (class 1) is acknowledged. `sda_low_o` is high from the falling edge after bit 8 until the falling edge after the ninth clock. `sel_o` rises with the acknowledge, and `rd_o` takes the direction bit (bit 0; 1 = master reads).
- R4: `sda_low_o` is released after the ninth clock and never changes while SCL is high.
- R5: Address 0000000 with direction 0 (class 2) is acknowledged only when `gc_en_i` is 1. When it is not accepted, the byte that follows gets no acknowledge and has no effect.
- R6: The following bytes are never acknowledged and leave `sel_o` low:
  - 0x01, the start byte (class 3);
  - address 0000001 with either direction (class 4);
  - addresses 00001xx (class 5);
  - addresses 11110xx (class 6);
  - addresses 000001x and 11111xx (class 7).
- R7: After an accepted general call, a second byte of 0x06 is acknowledged. At the end of its ninth clock, `gc_stb_o` and `gc_rst_o` pulse together for one cycle, and the programmable field is loaded from `prog_addr_i`.
- R8: After an accepted general call, a second byte of 0x04 is acknowledged, pulses `gc_stb_o` with `gc_rst_o` low and loads the programmable field. Any other even second byte is acknowledged with no strobe and no load.
- R9: After an accepted general call, an odd second byte is acknowledged. At the end of its ninth clock, `mst_stb_o` pulses and `mst_addr_o` holds bits 7..1 of that byte.
- R10: A start or repeated start at any point clears the bit count, drops `sel_o` and begins a new address phase.
- R11: A stop returns the block to idle with `sel_o` and `sda_low_o` low. Bytes clocked without a start are ignored.
- R12: The strobes `cls_stb_o`, `gc_stb_o` and `mst_stb_o` each last one cycle, and no two are high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| gc_en_i | input | 1 | Accept general calls when 1 |
| prog_addr_i | input | 7-FIX_W | Value for the programmable address field on reload |
| sda_low_o | output | 1 | Pull data line low (acknowledge) |
| sel_o | output | 1 | Device addressed in the current transfer |
| rd_o | output | 1 | Direction of the last own-address match (1 = master reads) |
| cls_stb_o | output | 1 | Address byte classified |
| cls_o | output | 3 | Class code of the last address byte |
| gc_stb_o | output | 1 | General-call command executed |
| gc_rst_o | output | 1 | The executed command was a reset |
| mst_stb_o | output | 1 | Calling master's address reported |
| mst_addr_o | output | 7 | Calling master's address |
| own_addr_o | output | 7 | Current own 7-bit address |

## Verification
A wrong bit count or a lost start shows up within one byte. The acknowledge then lands on the wrong clock or is missing, and the class strobe arrives on the wrong falling edge or carries a wrong code. A stale state after a stop or a repeated start shows as `sel_o` or `sda_low_o` still being high a few cycles after the bus event. A corrupted programmable field, or a command decoded when it should not be, changes `own_addr_o` without a matching `gc_stb_o`. The next own-address transfer is then left unacknowledged, so the bench sees the error no later than that transfer.

// File: rtl/i2c_adec_pkg.sv
package i2c_adec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_GCALL = 3'd2,
        ST_ACK   = 3'd3,
        ST_SEL   = 3'd4,
        ST_SKIP  = 3'd5
    } state_t;

    typedef enum logic [2:0] {
        CL_OTHER  = 3'd0,
        CL_OWN    = 3'd1,
        CL_GCALL  = 3'd2,
        CL_STBYTE = 3'd3,
        CL_CBUS   = 3'd4,
        CL_HSMC   = 3'd5,
        CL_TENBIT = 3'd6,
        CL_RSVD   = 3'd7
    } cls_t;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_RESET  = 2'd1,
        ACT_RELOAD = 2'd2,
        ACT_MASTER = 2'd3
    } gcact_t;

    localparam int          BYTE_W        = 8;
    localparam int          ADDR_W        = 7;
    localparam logic [7:0]  GCCMD_RESET   = 8'h06;
    localparam logic [7:0]  GCCMD_RELOAD  = 8'h04;

endpackage

// File: rtl/i2c_adec_events.sv
module i2c_adec_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q;
    logic sda_q;

    // Idle bus level is high on both wires.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise  =  scl_i & ~scl_q;
    assign scl_fall  = ~scl_i &  scl_q;
    assign bus_start =  scl_i &  scl_q &  sda_q & ~sda_i;
    assign bus_stop  =  scl_i &  scl_q & ~sda_q &  sda_i;

endmodule

// File: rtl/i2c_adec_shifter.sv
module i2c_adec_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic            rise,
    input  logic            din,
    output logic [BITS-1:0] data,
    output logic            full
);
    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0] cnt_q;

    assign full = (cnt_q == CNT_W'(BITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            data  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && rise && !full) begin
            data  <= {data[BITS-2:0], din};
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_adec_classify.sv
module i2c_adec_classify
    import i2c_adec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic              gc_en_i,
    output cls_t              cls,
    output logic              ack
);
    logic [ADDR_W-1:0] adr;
    logic              dir;

    assign adr = byte_i[BYTE_W-1:1];
    assign dir = byte_i[0];

    // Reserved codes take priority over the own-address compare.
    always_comb begin
        if (adr == 7'h00)
            cls = dir ? CL_STBYTE : CL_GCALL;
        else if (adr == 7'h01)
            cls = CL_CBUS;
        else if (adr[6:1] == 6'b000001)
            cls = CL_RSVD;
        else if (adr[6:2] == 5'b00001)
            cls = CL_HSMC;
        else if (adr[6:2] == 5'b11110)
            cls = CL_TENBIT;
        else if (adr[6:2] == 5'b11111)
            cls = CL_RSVD;
        else if (adr == own_i)
            cls = CL_OWN;
        else
            cls = CL_OTHER;
    end

    assign ack = (cls == CL_OWN) || ((cls == CL_GCALL) && gc_en_i);

endmodule

// File: rtl/i2c_adec.sv
module i2c_adec
    import i2c_adec_pkg::*;
#(
    parameter int               FIX_W     = 4,
    parameter logic [FIX_W-1:0] FIX_ADDR  = 4'hA,
    parameter logic [6-FIX_W:0] PROG_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             gc_en_i,
    input  logic [6-FIX_W:0] prog_addr_i,
    output logic             sda_low_o,
    output logic             sel_o,
    output logic             rd_o,
    output logic             cls_stb_o,
    output logic [2:0]       cls_o,
    output logic             gc_stb_o,
    output logic             gc_rst_o,
    output logic             mst_stb_o,
    output logic [6:0]       mst_addr_o,
    output logic [6:0]       own_addr_o
);
    localparam int PROG_W = ADDR_W - FIX_W;

    state_t              state_q, state_d;
    state_t              after_q;
    gcact_t              pend_q;
    cls_t                cls_q;
    cls_t                cls_w;
    logic                ack_w;
    logic [PROG_W-1:0]   prog_q;
    logic                scl_rise, scl_fall, bus_start, bus_stop;
    logic [BYTE_W-1:0]   sh_data;
    logic                sh_full;
    logic                shift_en;
    logic                ack_exit;
    logic                byte_end;

    assign own_addr_o = {FIX_ADDR, prog_q};
    assign cls_o      = cls_q;

    i2c_adec_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    assign shift_en = (state_q == ST_ADDR) || (state_q == ST_GCALL);
    assign byte_end = shift_en && sh_full && scl_fall;
    assign ack_exit = (state_q == ST_ACK) && scl_fall;

    i2c_adec_shifter #(.BITS(BYTE_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (bus_start | ack_exit),
        .en    (shift_en),
        .rise  (scl_rise),
        .din   (sda_i),
        .data  (sh_data),
        .full  (sh_full)
    );

    i2c_adec_classify u_cls (
        .byte_i  (sh_data),
        .own_i   (own_addr_o),
        .gc_en_i (gc_en_i),
        .cls     (cls_w),
        .ack     (ack_w)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_start) begin
            state_d = ST_ADDR;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SEL, ST_SKIP: state_d = state_q;
                ST_ADDR, ST_GCALL:        if (sh_full && scl_fall) state_d = ST_ACK;
                ST_ACK:                   if (scl_fall) state_d = after_q;
                default:                  state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs and decisions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_low_o  <= 1'b0;
            sel_o      <= 1'b0;
            rd_o       <= 1'b0;
            cls_stb_o  <= 1'b0;
            cls_q      <= CL_OTHER;
            gc_stb_o   <= 1'b0;
            gc_rst_o   <= 1'b0;
            mst_stb_o  <= 1'b0;
            mst_addr_o <= '0;
            after_q    <= ST_SKIP;
            pend_q     <= ACT_NONE;
            prog_q     <= PROG_INIT;
        end else begin
            cls_stb_o <= 1'b0;
            gc_stb_o  <= 1'b0;
            gc_rst_o  <= 1'b0;
            mst_stb_o <= 1'b0;
            if (bus_start || bus_stop) begin
                sda_low_o <= 1'b0;
                sel_o     <= 1'b0;
                pend_q    <= ACT_NONE;
            end else if (byte_end && state_q == ST_ADDR) begin
                sda_low_o <= ack_w;
                cls_stb_o <= 1'b1;
                cls_q     <= cls_w;
                pend_q    <= ACT_NONE;
                if (cls_w == CL_OWN) begin
                    sel_o   <= 1'b1;
                    rd_o    <= sh_data[0];
                    after_q <= ST_SEL;
                end else if (ack_w) begin
                    after_q <= ST_GCALL;
                end else begin
                    after_q <= ST_SKIP;
                end
            end else if (byte_end && state_q == ST_GCALL) begin
                sda_low_o <= 1'b1;
                after_q   <= ST_SKIP;
                if (sh_data[0])                  pend_q <= ACT_MASTER;
                else if (sh_data == GCCMD_RESET)  pend_q <= ACT_RESET;
                else if (sh_data == GCCMD_RELOAD) pend_q <= ACT_RELOAD;
                else                              pend_q <= ACT_NONE;
            end else if (ack_exit) begin
                sda_low_o <= 1'b0;
                pend_q    <= ACT_NONE;
                unique case (pend_q)
                    ACT_RESET: begin
                        gc_stb_o <= 1'b1;
                        gc_rst_o <= 1'b1;
                        prog_q   <= prog_addr_i;
                    end
                    ACT_RELOAD: begin
                        gc_stb_o <= 1'b1;
                        prog_q   <= prog_addr_i;
                    end
                    ACT_MASTER: begin
                        mst_stb_o  <= 1'b1;
                        mst_addr_o <= sh_data[BYTE_W-1:1];
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_adec_chk.sv
module i2c_adec_chk #(
    parameter int               FIX_W    = 4,
    parameter logic [FIX_W-1:0] FIX_ADDR = 4'hA
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic       sda_low_o,
    input logic       sel_o,
    input logic       cls_stb_o,
    input logic       gc_stb_o,
    input logic       gc_rst_o,
    input logic       mst_stb_o,
    input logic [6:0] own_addr_o
);
    // R4
    ack_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_low_o));

    // R11
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> (!sda_low_o && !sel_o));

    // R10
    start_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !sel_o);

    // R3
    sel_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> sda_low_o);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cls_stb_o, gc_stb_o, mst_stb_o}));

    // R12
    gc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_stb_o |=> !gc_stb_o);

    // R7
    rst_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_rst_o |-> gc_stb_o);

    // R2
    own_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(own_addr_o) |-> gc_stb_o);

    // R2
    fixed_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own_addr_o[6 -: FIX_W] == FIX_ADDR);

endmodule

bind i2c_adec i2c_adec_chk #(.FIX_W(FIX_W), .FIX_ADDR(FIX_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_low_o  (sda_low_o),
    .sel_o      (sel_o),
    .cls_stb_o  (cls_stb_o),
    .gc_stb_o   (gc_stb_o),
    .gc_rst_o   (gc_rst_o),
    .mst_stb_o  (mst_stb_o),
    .own_addr_o (own_addr_o)
);

// File: tb/i2c_adec_bench.sv
`timescale 1ns/1ps
module i2c_adec_bench;
    localparam int         Q       = 4;
    localparam logic [3:0] FIX     = 4'hA;
    localparam logic [2:0] P_INIT  = 3'd0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       gc_en = 1'b0;
    logic [2:0] prog_pin = 3'd0;
    logic       sda_bus;
    logic       sda_low_o, sel_o, rd_o, cls_stb_o, gc_stb_o, gc_rst_o, mst_stb_o;
    logic [2:0] cls_o;
    logic [6:0] mst_addr_o, own_addr_o;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;
    int n_cls = 0, n_gc = 0, n_mst = 0;
    logic [2:0] last_cls;
    logic       last_rst;
    logic [6:0] last_mst;
    logic [2:0] prog_model = P_INIT;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_low_o;

    i2c_adec u_i2c_adec (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .gc_en_i(gc_en),
        .prog_addr_i(prog_pin), .sda_low_o(sda_low_o), .sel_o(sel_o), .rd_o(rd_o),
        .cls_stb_o(cls_stb_o), .cls_o(cls_o), .gc_stb_o(gc_stb_o), .gc_rst_o(gc_rst_o),
        .mst_stb_o(mst_stb_o), .mst_addr_o(mst_addr_o), .own_addr_o(own_addr_o)
    );

    always @(negedge clk) begin
        if (cls_stb_o) begin n_cls++; last_cls = cls_o; end
        if (gc_stb_o)  begin n_gc++;  last_rst = gc_rst_o; end
        if (mst_stb_o) begin n_mst++; last_mst = mst_addr_o; end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] own_model();
        return {FIX, prog_model};
    endfunction

    function automatic int exp_cls(input logic [7:0] b);
        logic [6:0] a;
        a = b[7:1];
        if (a == 7'd0)                 return b[0] ? 3 : 2;
        if (a == 7'd1)                 return 4;
        if (a == 7'd2 || a == 7'd3)    return 7;
        if (a >= 7'h04 && a <= 7'h07)  return 5;
        if (a >= 7'h78 && a <= 7'h7B)  return 6;
        if (a >= 7'h7C)                return 7;
        if (a == own_model())          return 1;
        return 0;
    endfunction

    task automatic hp();
        repeat (Q) @(negedge clk);
    endtask

    task automatic send_start();
        sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
    endtask

    task automatic send_stop();
        sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; hp(); scl = 1'b1; hp(); scl = 1'b0; hp();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit held);
        send_bits(b, 8);
        sda_m = 1'b1; hp();
        scl = 1'b1; hp();
        acked = (sda_bus == 1'b0);
        scl = 1'b0; hp();
        held = sda_low_o;
    endtask

    // One complete transfer: address byte, optional second byte, stop
    task automatic txn(input logic [7:0] b1, input bit has2, input logic [7:0] b2);
        bit a, h;
        int c0, g0, m0, ec;
        bit eack, gc_ok;
        logic [2:0] pin_now;
        c0 = n_cls; g0 = n_gc; m0 = n_mst;
        ec = exp_cls(b1);
        gc_ok = (ec == 2) && gc_en;
        eack = (ec == 1) || gc_ok;
        send_start();
        send_byte(b1, a, h);
        chk(a == eack, (ec == 2) ? "R5" : (ec == 1 ? "R3" : "R6"), "address ack", a, eack);
        chk(n_cls == c0 + 1 && last_cls == ec[2:0], "R1", "class code", last_cls, ec);
        chk(h == 1'b0, "R4", "ack released", h, 0);
        chk(sel_o == (ec == 1), "R3", "select", sel_o, ec == 1);
        if (ec == 1) chk(rd_o == b1[0], "R3", "direction", rd_o, b1[0]);
        if (has2) begin
            pin_now = prog_pin;
            send_byte(b2, a, h);
            if (gc_ok) begin
                chk(a == 1'b1, "R8", "command ack", a, 1);
                if (b2[0]) begin
                    chk(n_mst == m0 + 1 && last_mst == b2[7:1], "R9", "master address", last_mst, b2[7:1]);
                    chk(n_gc == g0, "R9", "no command strobe", n_gc - g0, 0);
                end else if (b2 == 8'h06 || b2 == 8'h04) begin
                    chk(n_gc == g0 + 1 && last_rst == (b2 == 8'h06),
                        (b2 == 8'h06) ? "R7" : "R8", "command strobe", last_rst, b2 == 8'h06);
                    prog_model = pin_now;
                end else begin
                    chk(n_gc == g0 && n_mst == m0, "R8", "unknown command ignored", n_gc - g0, 0);
                end
            end else begin
                chk(a == 1'b0 && n_gc == g0 && n_mst == m0, "R5", "unaccepted second byte", a, 0);
            end
            chk(own_addr_o == own_model(), "R2", "own address", own_addr_o, own_model());
        end
        send_stop();
        hp();
        chk(sel_o == 1'b0 && sda_low_o == 1'b0, "R11", "idle after stop", {sel_o, sda_low_o}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        bit a, h;
        int c0;
        logic [7:0] b1, b2;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        hp();
        chk(sda_low_o == 0 && sel_o == 0, "R11", "reset outputs", {sda_low_o, sel_o}, 0);
        chk(own_addr_o == {FIX, P_INIT}, "R2", "reset address", own_addr_o, {FIX, P_INIT});

        // Directed cases
        txn({own_model(), 1'b0}, 1'b0, 8'h00);
        txn({own_model(), 1'b1}, 1'b0, 8'h00);
        gc_en = 1'b0; prog_pin = 3'd5;
        txn(8'h00, 1'b1, 8'h06);
        gc_en = 1'b1;
        txn(8'h00, 1'b1, 8'h06);
        prog_pin = 3'd3;
        txn(8'h00, 1'b1, 8'h04);
        prog_pin = 3'd6;
        txn(8'h00, 1'b1, 8'h02);
        txn(8'h00, 1'b1, 8'hA5);
        txn(8'hF3, 1'b0, 8'h00);
        txn(8'h0B, 1'b0, 8'h00);

        // Start byte, then repeated start to own address (R6, R10)
        c0 = n_cls;
        send_start();
        send_byte(8'h01, a, h);
        chk(a == 0 && last_cls == 3'd3, "R6", "start byte not acked", a, 0);
        send_start();
        send_byte({own_model(), 1'b0}, a, h);
        chk(a == 1 && n_cls == c0 + 2, "R10", "address after repeated start", a, 1);
        send_start();
        chk(sel_o == 0, "R10", "repeated start deselects", sel_o, 0);
        // Restart in the middle of a byte
        send_bits(8'h00, 4);
        send_start();
        send_byte({own_model(), 1'b1}, a, h);
        chk(a == 1 && rd_o == 1, "R10", "mid-byte restart", {a, rd_o}, 3);
        send_stop();
        hp();

        // Byte without start is ignored (R11)
        c0 = n_cls;
        scl = 1'b0; hp();
        send_byte({own_model(), 1'b0}, a, h);
        chk(a == 0 && n_cls == c0 && sel_o == 0, "R11", "byte without start", a, 0);
        sda_m = 1'b1; scl = 1'b1; hp();

        // Random transfers
        for (int t = 0; t < 150; t++) begin
            int k;
            k = int'($urandom % 8);
            gc_en = 1'($urandom % 2);
            prog_pin = 3'($urandom % 8);
            case (k)
                0: b1 = {own_model(), 1'($urandom % 2)};
                1: b1 = 8'h00;
                2: b1 = 8'h01;
                3: b1 = {7'h01, 1'($urandom % 2)};
                4: b1 = 8'h08 | 8'($urandom % 8);
                5: b1 = 8'hF0 | 8'($urandom % 8);
                default: b1 = 8'($urandom);
            endcase
            case ($urandom % 4)
                0: b2 = 8'h06;
                1: b2 = 8'h04;
                2: b2 = {7'($urandom), 1'b1};
                default: begin
                    b2 = {7'($urandom), 1'b0};
                    if (b2 == 8'h06 || b2 == 8'h04) b2 = 8'h0A;
                end
            endcase
            txn(b1, (b1 == 8'h00), b2);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule